// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This block performs the shift and rotate family of integer operations for an execution pipeline. It supports arithmetic shift, logical shift, plain rotate and rotate-through-extend. Each operation can go left or right, on an 8-, 16- or 32-bit operand. With each result it returns the five condition flags: negative, zero, overflow, carry and extend.

The issuing stage supplies the operand, the size, the operation class, the direction and the current extend flag. It also supplies the shift count and says where that count comes from: a register value or a 3-bit immediate field. A separate single-bit memory form forces a word-sized operation by exactly one position. The unit reduces the count the same way for every class. The result and flags are registered one clock after an accepted input. Operand fetch and writeback are handled elsewhere.

Top module: `shift_rotate_unit`

## Requirements
- R1: With `cnt_from_reg`=1 the count is `reg_count[5:0]` (the register value modulo 64). With `cnt_from_reg`=0 the count is `imm_count`, and the code 0 means 8, which gives a range of 1 to 8.
- R2: When `mem_form`=1 the operation is word sized (16 bits) and shifts by exactly one, whatever `size`, `cnt_from_reg`, `imm_count` and `reg_count` hold.
- R3: Fill and loop rules apply within the active width. The `op` encoding is 0 arithmetic, 1 logical, 2 rotate, 3 rotate-through-extend, and `dir_left`=1 selects left. An arithmetic right shift fills with the sign bit. Every other shift fills with zero. A rotate feeds each bit that leaves back in at the other end. Rotate-through-extend runs the loop through X, so the loop is one bit wider than the operand.
- R4: For arithmetic and logical shifts, C and X both take the last bit shifted out. With a count of zero, C is 0 and X equals `x_in`.
- R5: For an arithmetic left shift, V is 1 when the operand's most significant bit takes a different value at any step of the shift. V is 0 for arithmetic right shifts, logical shifts and both rotate classes.
- R6: A plain rotate puts the last bit rotated out into C and leaves X equal to `x_in`. With a count of zero, C is 0.
- R7: Rotate-through-extend puts the last bit rotated out into both C and X. With a count of zero, C equals `x_in` and X equals `x_in`.
- R8: N equals the most significant bit of the sized result. Z is 1 exactly when all sized result bits are 0. The `size` encoding is 0 byte, 1 word, 2 or 3 long.
- R9: Result bits above the active width equal the corresponding operand bits.
- R10: `out_valid` is `in_valid` delayed by one clock, and result and flags belong to that accepted input. A synchronous reset (`rst_n`=0) clears `out_valid`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| operand | input | 32 | Value to shift or rotate |
| size | input | 2 | 0 byte, 1 word, 2/3 long |
| op | input | 2 | 0 arithmetic, 1 logical, 2 rotate, 3 rotate through X |
| dir_left | input | 1 | 1 left, 0 right |
| cnt_from_reg | input | 1 | 1 count from `reg_count`, 0 from `imm_count` |
| imm_count | input | 3 | Immediate count, 0 encodes 8 |
| reg_count | input | 32 | Register count, used modulo 64 |
| mem_form | input | 1 | Single-bit word-sized form |
| x_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result and flags valid |
| result | output | 32 | Shifted or rotated value |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |
| flag_x | output | 1 | Extend |

## Verification
The hardest case to reach is the arithmetic left shift whose sign bit changes and then changes back, so the final result looks harmless while V must still be set. The stimulus uses byte operands such as 0x40 shifted by two, and register counts larger than the operand width, which push every operand bit through the sign position. The other hard cases are counts of exactly zero and register counts at or above 64. These are the only way to see the zero-count carry rules and the modulo-64 wrap. Directed vectors cover them for every class, and a pseudo-random sweep covers the rest.

// File: rtl/srt_pkg.sv
// Package: shared encodings and width helpers for the shift/rotate unit.
// Assumes a 32-bit datapath; byte and word operands sit in the low bits.
package srt_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        OP_ARITH = 2'd0,
        OP_LOGIC = 2'd1,
        OP_ROT   = 2'd2,
        OP_ROTX  = 2'd3
    } op_e;

    // Mask of the bits inside the active operand width.
    function automatic logic [DATA_W-1:0] active_mask(input size_e sz);
        case (sz)
            SZ_BYTE: active_mask = 32'h0000_00FF;
            SZ_WORD: active_mask = 32'h0000_FFFF;
            default: active_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // One-hot marker of the sign position for the active width.
    function automatic logic [DATA_W-1:0] sign_onehot(input size_e sz);
        case (sz)
            SZ_BYTE: sign_onehot = 32'h0000_0080;
            SZ_WORD: sign_onehot = 32'h0000_8000;
            default: sign_onehot = 32'h8000_0000;
        endcase
    endfunction

endpackage

// File: rtl/srt_count_dec.sv
// Module: srt_count_dec
// Turns the count source fields into an effective step count and size.
// Assumes REG_BITS bits of the register count are significant (modulo 2**REG_BITS)
// and that an immediate code of zero stands for 2**IMM_BITS.
module srt_count_dec
    import srt_pkg::*;
#(
    parameter int REG_BITS = 6,
    parameter int IMM_BITS = 3
) (
    input  logic                cnt_from_reg,
    input  logic [IMM_BITS-1:0] imm_count,
    input  logic [DATA_W-1:0]   reg_count,
    input  logic                mem_form,
    input  size_e               size_in,
    output logic [REG_BITS-1:0] steps,
    output size_e               size_eff
);

    localparam int IMM_FULL = 1 << IMM_BITS;

    // Select the count source and apply the memory-form override.
    always_comb begin
        if (mem_form) begin
            steps    = REG_BITS'(1);
            size_eff = SZ_WORD;
        end else begin
            size_eff = size_in;
            if (cnt_from_reg)
                steps = reg_count[REG_BITS-1:0];
            else if (imm_count == '0)
                steps = REG_BITS'(IMM_FULL);
            else
                steps = REG_BITS'(imm_count);
        end
    end

    // An immediate-sourced count can never reach the chain as zero.
    always_comb begin
        if (!cnt_from_reg)
            AST_IMM_NONZERO: assert (steps != '0); // R1
    end

endmodule

// File: rtl/srt_step.sv
// Module: srt_step
// One single-position shift or rotate stage with running flag update.
// Assumes mask/sign_oh describe the active width; bits above it are held.
// When en is low every output equals its input.
module srt_step
    import srt_pkg::*;
(
    input  logic              en,
    input  op_e               op,
    input  logic              left,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] sign_oh,
    input  logic [DATA_W-1:0] val_i,
    input  logic              x_i,
    input  logic              c_i,
    input  logic              v_i,
    output logic [DATA_W-1:0] val_o,
    output logic              x_o,
    output logic              c_o,
    output logic              v_o
);

    logic              sign_old;
    logic              sign_new;
    logic              out_bit;
    logic              fill_bit;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] stepped;

    // Pick the departing bit and the bit that enters at the other end.
    always_comb begin
        sign_old = |(val_i & sign_oh);
        out_bit  = left ? sign_old : val_i[0];
        case (op)
            OP_ARITH: fill_bit = left ? 1'b0 : sign_old;
            OP_LOGIC: fill_bit = 1'b0;
            OP_ROT:   fill_bit = out_bit;
            default:  fill_bit = x_i;
        endcase
    end

    // Move the active bits by one and restore the bits above the width.
    always_comb begin
        if (left)
            moved = (val_i << 1) | DATA_W'(fill_bit);
        else
            moved = ((val_i >> 1) & ~sign_oh) | (fill_bit ? sign_oh : '0);
        stepped  = (moved & mask) | (val_i & ~mask);
        sign_new = |(stepped & sign_oh);
    end

    // Apply the stage or pass everything through.
    always_comb begin
        if (en) begin
            val_o = stepped;
            c_o   = out_bit;
            x_o   = (op == OP_ROT) ? x_i : out_bit;
            v_o   = v_i | ((op == OP_ARITH) && left && (sign_new != sign_old));
        end else begin
            val_o = val_i;
            c_o   = c_i;
            x_o   = x_i;
            v_o   = v_i;
        end
    end

endmodule

// File: rtl/srt_flags.sv
// Module: srt_flags
// Derives the negative and zero flags from the sized result.
// Assumes mask and sign_oh match the width used to produce the value.
module srt_flags
    import srt_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] sign_oh,
    output logic              neg,
    output logic              zero
);

    // Look only at the bits inside the active width.
    always_comb begin
        neg  = |(value & sign_oh);
        zero = ((value & mask) == '0);
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit
// Sized shift/rotate unit with condition flags and one register stage.
// Assumes the caller presents one operation per cycle qualified by in_valid;
// the count is decoded, then a chain of single-position stages applies it.
module shift_rotate_unit
    import srt_pkg::*;
#(
    parameter int REG_BITS = 6,
    parameter int IMM_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   operand,
    input  logic [1:0]          size,
    input  logic [1:0]          op,
    input  logic                dir_left,
    input  logic                cnt_from_reg,
    input  logic [IMM_BITS-1:0] imm_count,
    input  logic [DATA_W-1:0]   reg_count,
    input  logic                mem_form,
    input  logic                x_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic                flag_c,
    output logic                flag_x
);

    localparam int MAX_STEPS = (1 << REG_BITS) - 1;

    op_e                 op_q;
    size_e               size_eff;
    logic [REG_BITS-1:0] steps;
    logic [DATA_W-1:0]   mask;
    logic [DATA_W-1:0]   sign_oh;
    logic                res_n;
    logic                res_z;

    logic [DATA_W-1:0] chain_val [0:MAX_STEPS];
    logic              chain_x   [0:MAX_STEPS];
    logic              chain_c   [0:MAX_STEPS];
    logic              chain_v   [0:MAX_STEPS];

    srt_count_dec #(
        .REG_BITS (REG_BITS),
        .IMM_BITS (IMM_BITS)
    ) count_i (
        .cnt_from_reg (cnt_from_reg),
        .imm_count    (imm_count),
        .reg_count    (reg_count),
        .mem_form     (mem_form),
        .size_in      (size_e'(size)),
        .steps        (steps),
        .size_eff     (size_eff)
    );

    // Width helpers and the chain's starting state (zero-count values).
    always_comb begin
        op_q         = op_e'(op);
        mask         = active_mask(size_eff);
        sign_oh      = sign_onehot(size_eff);
        chain_val[0] = operand;
        chain_x[0]   = x_in;
        chain_c[0]   = (op_q == OP_ROTX) ? x_in : 1'b0;
        chain_v[0]   = 1'b0;
    end

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_step
        srt_step step_i (
            .en      (steps > REG_BITS'(g)),
            .op      (op_q),
            .left    (dir_left),
            .mask    (mask),
            .sign_oh (sign_oh),
            .val_i   (chain_val[g]),
            .x_i     (chain_x[g]),
            .c_i     (chain_c[g]),
            .v_i     (chain_v[g]),
            .val_o   (chain_val[g+1]),
            .x_o     (chain_x[g+1]),
            .c_o     (chain_c[g+1]),
            .v_o     (chain_v[g+1])
        );
    end

    srt_flags flags_i (
        .value   (chain_val[MAX_STEPS]),
        .mask    (mask),
        .sign_oh (sign_oh),
        .neg     (res_n),
        .zero    (res_z)
    );

    // Register the result and flags of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
            flag_x    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= chain_val[MAX_STEPS];
                flag_n <= res_n;
                flag_z <= res_z;
                flag_v <= chain_v[MAX_STEPS];
                flag_c <= chain_c[MAX_STEPS];
                flag_x <= chain_x[MAX_STEPS];
            end
        end
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_BYTE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd0 && !mem_form) |=> result[31:8] == $past(operand[31:8])); // R9
    AST_NONARITH_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'd0) |=> !flag_v); // R5
    AST_ASR_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd0 && !dir_left) |=> !flag_v); // R5
    AST_ROT_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> flag_x == $past(x_in)); // R6

endmodule

// File: tb/shift_rotate_unit_tb.sv
// Bench: scoreboard around shift_rotate_unit. The driver pushes expected
// values computed from the requirements; the monitor pops and compares.
module shift_rotate_unit_tb_top;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [31:0] r;
        logic n, z, v, c, x;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = '0;
    logic [1:0]  op = '0;
    logic        dir_left = 1'b0;
    logic        cnt_from_reg = 1'b0;
    logic [2:0]  imm_count = '0;
    logic [31:0] reg_count = '0;
    logic        mem_form = 1'b0;
    logic        x_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    exp_t  expq [$];
    string tagq [$];

    always #(CLK_P/2) clk = ~clk;

    shift_rotate_unit dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .operand (operand),
        .size (size), .op (op), .dir_left (dir_left), .cnt_from_reg (cnt_from_reg),
        .imm_count (imm_count), .reg_count (reg_count), .mem_form (mem_form),
        .x_in (x_in), .out_valid (out_valid), .result (result), .flag_n (flag_n),
        .flag_z (flag_z), .flag_v (flag_v), .flag_c (flag_c), .flag_x (flag_x)
    );

    // Behavioural expectation, stepping one bit position at a time.
    function automatic exp_t model(logic [31:0] opnd, logic [1:0] sz, logic [1:0] opc,
                                   logic lf, logic from_reg, logic [2:0] imm,
                                   logic [31:0] rc, logic mem, logic xi);
        exp_t e;
        int w, k;
        logic [31:0] v;
        logic cf, xf, vf, ob, fb, s0;
        w = mem ? 16 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        k = mem ? 1 : from_reg ? int'(rc[5:0]) : (imm == 3'd0) ? 8 : int'(imm);
        v = opnd; xf = xi; cf = (opc == 2'd3) ? xi : 1'b0; vf = 1'b0;
        for (int i = 0; i < k; i++) begin
            s0 = v[w-1];
            if (lf) begin
                ob = v[w-1];
                fb = (opc == 2'd2) ? ob : (opc == 2'd3) ? xf : 1'b0;
                for (int b = w - 1; b > 0; b--) v[b] = v[b-1];
                v[0] = fb;
            end else begin
                ob = v[0];
                fb = (opc == 2'd0) ? v[w-1] : (opc == 2'd2) ? ob : (opc == 2'd3) ? xf : 1'b0;
                for (int b = 0; b < w - 1; b++) v[b] = v[b+1];
                v[w-1] = fb;
            end
            if (opc == 2'd0 && v[w-1] != s0) vf = 1'b1;
            cf = ob;
            if (opc != 2'd2) xf = ob;
        end
        e.r = v; e.n = v[w-1]; e.v = vf; e.c = cf; e.x = xf;
        e.z = (w == 8) ? (v[7:0] == 0) : (w == 16) ? (v[15:0] == 0) : (v == 0);
        return e;
    endfunction

    // Driver: present one operation and queue what it must produce.
    task automatic drive(string tag, logic [31:0] opnd, logic [1:0] sz, logic [1:0] opc,
                         logic lf, logic from_reg, logic [2:0] imm, logic [31:0] rc,
                         logic mem, logic xi);
        @(negedge clk);
        in_valid = 1'b1; operand = opnd; size = sz; op = opc; dir_left = lf;
        cnt_from_reg = from_reg; imm_count = imm; reg_count = rc; mem_form = mem; x_in = xi;
        expq.push_back(model(opnd, sz, opc, lf, from_reg, imm, rc, mem, xi));
        tagq.push_back(tag);
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            exp_t e;
            string t;
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected out_valid act=%h exp=none", result);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                if ({result, flag_n, flag_z, flag_v, flag_c, flag_x} !== e) begin
                    errors++;
                    $display("FAIL %s act r=%h nzvcx=%b%b%b%b%b exp r=%h nzvcx=%b%b%b%b%b",
                             t, result, flag_n, flag_z, flag_v, flag_c, flag_x,
                             e.r, e.n, e.z, e.v, e.c, e.x);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1234_5678;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || {flag_n, flag_z, flag_v, flag_c, flag_x} !== 5'b0) begin
            errors++;
            $display("FAIL R10 reset state act v=%b r=%h exp v=0 r=0", out_valid, result);
        end
        rst_n = 1'b1;

        // R1 count decode
        drive("R1 reg count 65 wraps to 1", 32'h0000_8001, 2'd1, 2'd1, 1'b1, 1'b1, 3'd0, 32'd65, 1'b0, 1'b0);
        drive("R1 reg count 64 wraps to 0", 32'h0000_00F3, 2'd0, 2'd1, 1'b1, 1'b1, 3'd0, 32'd64, 1'b0, 1'b1);
        drive("R1 imm 0 means 8", 32'h0000_00FF, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0, 1'b0);
        drive("R1 imm 3", 32'h0000_00B4, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 32'd0, 1'b0, 1'b0);
        // R2 memory form
        drive("R2 mem form ignores byte size and count", 32'hAAAA_C001, 2'd0, 2'd0, 1'b1, 1'b1, 3'd5, 32'd9, 1'b1, 1'b0);
        drive("R2 mem form right rotate", 32'h1234_0001, 2'd2, 2'd2, 1'b0, 1'b0, 3'd7, 32'd0, 1'b1, 1'b0);
        // R3 fill rules
        drive("R3 asr fills sign", 32'h0000_0080, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 32'd0, 1'b0, 1'b0);
        drive("R3 lsr fills zero", 32'h0000_0080, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3, 32'd0, 1'b0, 1'b0);
        drive("R3 ror circular", 32'h0000_0081, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R3 roxl through X 9-bit loop", 32'h0000_0001, 2'd0, 2'd3, 1'b1, 1'b1, 3'd0, 32'd9, 1'b0, 1'b1);
        // R4 shift carry/extend
        drive("R4 lsl long last bit out", 32'h8000_0000, 2'd2, 2'd1, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R4 zero count shift keeps X", 32'hFFFF_FFFF, 2'd2, 2'd0, 1'b1, 1'b1, 3'd0, 32'd0, 1'b0, 1'b1);
        // R5 overflow
        drive("R5 asl sign change", 32'h0000_0040, 2'd0, 2'd0, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R5 asl no sign change", 32'h0000_00C0, 2'd0, 2'd0, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R5 asl change and back", 32'h0000_0040, 2'd0, 2'd0, 1'b1, 1'b0, 3'd2, 32'd0, 1'b0, 1'b0);
        drive("R5 asl long count 63", 32'h0000_0001, 2'd2, 2'd0, 1'b1, 1'b1, 3'd0, 32'd63, 1'b0, 1'b0);
        drive("R5 lsl V clear", 32'h0000_4000, 2'd1, 2'd1, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        // R6 plain rotate
        drive("R6 rol keeps X", 32'h0000_8000, 2'd1, 2'd2, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b1);
        drive("R6 rotate count 0 clears C", 32'h0000_0001, 2'd0, 2'd2, 1'b0, 1'b1, 3'd0, 32'd128, 1'b0, 1'b1);
        // R7 rotate through X
        drive("R7 roxr last bit to X", 32'h0000_0001, 2'd1, 2'd3, 1'b0, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R7 roxl count 0 C equals X", 32'h0000_0000, 2'd2, 2'd3, 1'b1, 1'b1, 3'd0, 32'd0, 1'b0, 1'b1);
        // R8 N/Z and R9 upper bits
        drive("R8 word zero result", 32'hFFFF_8000, 2'd1, 2'd1, 1'b1, 1'b0, 3'd1, 32'd0, 1'b0, 1'b0);
        drive("R9 byte upper bits held", 32'hDEAD_BE0F, 2'd0, 2'd0, 1'b1, 1'b1, 3'd0, 32'd40, 1'b0, 1'b0);
        drive("R9 word upper bits held", 32'hCAFE_0F0F, 2'd1, 2'd3, 1'b0, 1'b1, 3'd0, 32'd20, 1'b0, 1'b1);
        // Pseudo-random sweep
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr ^ (lfsr << 7);
            drive("R8 sweep", a, lfsr[1:0], lfsr[3:2], lfsr[4], lfsr[5], lfsr[8:6],
                  {26'd0, lfsr[14:9]}, (lfsr[17:15] == 3'd0), lfsr[18]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || expq.size() != 0) begin
            errors++;
            $display("FAIL R10 idle act v=%b pending=%0d exp v=0 pending=0", out_valid, expq.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule